// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line and reports them through a small set of read-only registers. It is timed by an oversampling tick input: every bit period lasts sixteen ticks. Each bit is settled by a majority vote over three samples taken near the middle of the bit. Characters carry either eight or nine frame bits, sent LSB first. When parity is enabled, the last frame bit is the parity bit.

A processor reads two status registers and a data register over a read-only register bus. A status flag is cleared by a two-step sequence. First the processor reads the status register that holds the flag while the flag is set. Then it reads the data register. Only the flags seen set during the status read are cleared, so a flag that sets between the two reads survives. A break character sets a dedicated flag. That flag can set again only after the line has been seen high. A reception-busy flag follows start-bit detection, false starts and idle lines. A parity error raises an error interrupt when its enable is set.

Top module: `uart_rx_status`

## Requirements
- R1: A bit lasts 16 ticks. The first tick that samples `rxd` low while idle is tick 1 of the start bit. Each bit value is the majority of ticks 8, 9 and 10. Frame bits arrive LSB first: 8 of them, or 9 when `nine_bit_en` is 1. A read of address 2 returns frame bits 7:0. A read of address 3 returns frame bit 8 in bit 7, with zeros elsewhere.
- R2: When `par_en` is 1, the last frame bit is parity. The parity error flag (address 0, bit 0) sets when the XOR of all frame bits differs from `par_odd`.
- R3: Every completed character sets the receive-full flag (address 0, bit 5). A stop sample of 0 also sets the framing error flag (address 0, bit 1).
- R4: The flags at address 0 clear only in this sequence: address 0 is read while the flag is set, and address 2 is read afterwards. A data read on its own clears nothing. A flag that sets after the status read stays set.
- R5: `err_irq` is high exactly when the parity error flag is set and `perr_ie` is 1.
- R6: A character whose frame bits and stop sample are all 0 is a break. A break sets the break flag (address 1, bit 1) together with the framing error flag and the receive-full flag. In 9-bit mode, the ninth bit then reads 0.
- R7: The break flag clears when address 1 is read while the flag is set and address 2 is read afterwards. A data read on its own leaves it set.
- R8: After a break, a further break sets the break flag only if a tick has sampled `rxd` high in between.
- R9: The busy flag (address 1, bit 0) sets on the tick that first samples `rxd` low while the receiver is idle. It stays set through the character.
- R10: If the start-bit majority vote gives 1, the start is false. The busy flag clears and no character is loaded.
- R11: The busy flag clears after 16*(frame bits + 2) consecutive ticks with `rxd` high while the receiver is idle. It stays set before that count is reached.
- R12: After reset every register reads 0x00. Bits 7:2 of address 1 and bits 7:6, 4:2 of address 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial input line, idle high |
| nine_bit_en | input | 1 | 1 selects 9 frame bits, 0 selects 8 |
| par_en | input | 1 | Last frame bit is parity |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| perr_ie | input | 1 | Parity error interrupt enable |
| rd_en | input | 1 | Register read strobe, one cycle |
| rd_addr | input | 2 | 0 status 1, 1 status 2, 2 data, 3 ninth bit |
| rd_data | output | 8 | Read data for `rd_addr` |
| err_irq | output | 1 | Parity error interrupt request |

## Verification
The hardest case to reach is the break re-arm rule. The line has to stay low across two complete characters while the first break flag is cleared between them. The bench holds `rxd` at 0 for the whole span and performs the status-then-data clear in the middle of the second character. It then expects the framing error without the break flag. After that it lets the line idle high and sends a fresh break to see the flag return. The race between a status read and a late-arriving character is produced by issuing the status read inside the stop bit, before the mid-bit vote completes the character.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_e;

  typedef struct packed {
    logic rf;
    logic fe;
    logic pe;
  } s1_flags_t;

  localparam logic [1:0] A_STAT1 = 2'd0;
  localparam logic [1:0] A_STAT2 = 2'd1;
  localparam logic [1:0] A_DATA  = 2'd2;
  localparam logic [1:0] A_AUX   = 2'd3;
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler #(
  parameter int OSR  = 16,
  parameter int MAXB = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  input  logic            nine_bit_en,
  output logic            frame_done,
  output logic [MAXB-1:0] frame_bits,
  output logic            stop_bit,
  output logic            start_seen,
  output logic            false_start,
  output logic            idle_seen
);
  import urx_pkg::*;

  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(MAXB);
  localparam int IDW = $clog2(OSR*(MAXB+2)+1);
  localparam int MID = OSR/2;

  rx_st_e          st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [BW-1:0]   bidx, bidx_n, last_idx;
  logic [MAXB-1:0] sh, sh_n;
  logic [1:0]      vs, vs_n;
  logic [IDW-1:0]  idle_cnt, idle_n, idle_lim;
  logic            vote;

  assign idle_lim = nine_bit_en ? IDW'(OSR*(MAXB+2)) : IDW'(OSR*(MAXB+1));
  assign last_idx = nine_bit_en ? BW'(MAXB-1) : BW'(MAXB-2);
  assign vote     = (vs[0] & vs[1]) | (vs[0] & rxd) | (vs[1] & rxd);
  assign frame_bits = sh;
  assign stop_bit   = vote;

  always_comb begin
    st_n = st; cnt_n = cnt; bidx_n = bidx; sh_n = sh; vs_n = vs; idle_n = idle_cnt;
    start_seen = 1'b0; false_start = 1'b0; frame_done = 1'b0; idle_seen = 1'b0;
    if (tick) begin
      if (st == ST_IDLE) begin
        if (!rxd) begin
          st_n = ST_START; cnt_n = CW'(1); sh_n = '0; idle_n = '0; start_seen = 1'b1;
        end else if (idle_cnt < idle_lim) begin
          idle_n    = idle_cnt + IDW'(1);
          idle_seen = (idle_cnt + IDW'(1)) == idle_lim;
        end
      end else begin
        cnt_n = (cnt == CW'(OSR-1)) ? '0 : cnt + CW'(1);
        if (cnt == CW'(MID-1)) vs_n[0] = rxd;
        if (cnt == CW'(MID))   vs_n[1] = rxd;
        if (cnt == CW'(MID+1)) begin
          case (st)
            ST_START: if (vote) begin st_n = ST_IDLE; false_start = 1'b1; end
            ST_DATA:  sh_n[bidx] = vote;
            ST_STOP:  begin st_n = ST_IDLE; frame_done = 1'b1; end
            default:  ;
          endcase
        end
        if (cnt == CW'(OSR-1)) begin
          if (st == ST_START) begin
            st_n = ST_DATA; bidx_n = '0;
          end else if (st == ST_DATA) begin
            if (bidx == last_idx) st_n = ST_STOP;
            else bidx_n = bidx + BW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; bidx <= '0; sh <= '0; vs <= '0; idle_cnt <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; bidx <= bidx_n; sh <= sh_n; vs <= vs_n; idle_cnt <= idle_n;
    end
  end
endmodule

// File: rtl/urx_regs.sv
module urx_regs #(
  parameter int DW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxd,
  input  logic                frame_done,
  input  logic [DW-1:0]       frame_bits,
  input  logic                stop_bit,
  input  logic                start_seen,
  input  logic                false_start,
  input  logic                idle_seen,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                rd_en,
  input  logic [1:0]          rd_addr,
  output urx_pkg::s1_flags_t  s1_q,
  output logic                bk_q,
  output logic                busy_q,
  output logic [DW-1:0]       dat_q
);
  import urx_pkg::*;

  s1_flags_t     s1_n, arm1, arm1_n, clr1;
  logic          bk_n, busy_n, brk_ok, brk_ok_n, arm2, arm2_n;
  logic [DW-1:0] dat_n;
  logic          brk, par_bad, rd_s1, rd_s2, rd_dat;

  assign brk     = frame_done & ~(|frame_bits) & ~stop_bit;
  assign par_bad = par_en & ((^frame_bits) != par_odd);
  assign rd_s1   = rd_en & (rd_addr == A_STAT1);
  assign rd_s2   = rd_en & (rd_addr == A_STAT2);
  assign rd_dat  = rd_en & (rd_addr == A_DATA);

  always_comb begin
    clr1      = rd_dat ? arm1 : '0;
    s1_n.rf   = (s1_q.rf & ~clr1.rf) | frame_done;
    s1_n.fe   = (s1_q.fe & ~clr1.fe) | (frame_done & ~stop_bit);
    s1_n.pe   = (s1_q.pe & ~clr1.pe) | (frame_done & par_bad);
    bk_n      = (bk_q & ~(rd_dat & arm2)) | (brk & brk_ok);
    brk_ok_n  = brk ? 1'b0 : ((tick & rxd) ? 1'b1 : brk_ok);
    busy_n    = start_seen ? 1'b1 : ((false_start | idle_seen) ? 1'b0 : busy_q);
    arm1_n    = rd_s1 ? s1_q : (rd_dat ? '0 : arm1);
    arm2_n    = rd_s2 ? bk_q : (rd_dat ? 1'b0 : arm2);
    dat_n     = frame_done ? frame_bits : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; bk_q <= 1'b0; busy_q <= 1'b0; brk_ok <= 1'b1;
      arm1 <= '0; arm2 <= 1'b0; dat_q <= '0;
    end else begin
      s1_q <= s1_n; bk_q <= bk_n; busy_q <= busy_n; brk_ok <= brk_ok_n;
      arm1 <= arm1_n; arm2 <= arm2_n; dat_q <= dat_n;
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       nine_bit_en,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       perr_ie,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       err_irq
);
  import urx_pkg::*;

  localparam int DW = 9;

  logic          frame_done, stop_bit, start_seen, false_start, idle_seen;
  logic [DW-1:0] frame_bits, dat_q;
  s1_flags_t     s1_q;
  logic          bk_q, busy_q;

  urx_sampler #(.OSR(OSR), .MAXB(DW)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_bit_en(nine_bit_en),
    .frame_done(frame_done), .frame_bits(frame_bits), .stop_bit(stop_bit),
    .start_seen(start_seen), .false_start(false_start), .idle_seen(idle_seen)
  );

  urx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .frame_done(frame_done), .frame_bits(frame_bits), .stop_bit(stop_bit),
    .start_seen(start_seen), .false_start(false_start), .idle_seen(idle_seen),
    .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en), .rd_addr(rd_addr),
    .s1_q(s1_q), .bk_q(bk_q), .busy_q(busy_q), .dat_q(dat_q)
  );

  always_comb begin
    case (rd_addr)
      A_STAT1: rd_data = {2'b00, s1_q.rf, 3'b000, s1_q.fe, s1_q.pe};
      A_STAT2: rd_data = {6'b000000, bk_q, busy_q};
      A_DATA:  rd_data = dat_q[7:0];
      default: rd_data = {dat_q[DW-1], 7'b0000000};
    endcase
  end

  assign err_irq = s1_q.pe & perr_ie;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rxd,
  input logic       perr_ie,
  input logic       rd_en,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       err_irq,
  input logic       pe_q,
  input logic       fe_q,
  input logic       rf_q,
  input logic       bk_q,
  input logic       busy_q
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (perr_ie && pe_q)); // R5
  AST_S2_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd1) |-> (rd_data[7:2] == 6'd0)); // R12
  AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_q && !(rd_en && rd_addr == 2'd2)) |=> pe_q); // R4
  AST_BK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_q && !(rd_en && rd_addr == 2'd2)) |=> bk_q); // R7
  AST_BK_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bk_q) |-> (fe_q && rf_q)); // R6
  AST_BUSY_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tick && !rxd)); // R9
endmodule

bind uart_rx_status uart_rx_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .perr_ie(perr_ie),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .err_irq(err_irq),
  .pe_q(s1_q.pe), .fe_q(s1_q.fe), .rf_q(s1_q.rf), .bk_q(bk_q), .busy_q(busy_q)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  logic       clk, rst_n, tick, rxd, nine_bit_en, par_en, par_odd, perr_ie, rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       err_irq;
  int         n_chk, n_fail;
  logic [7:0] d;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nine_bit_en(nine_bit_en),
    .par_en(par_en), .par_odd(par_odd), .perr_ie(perr_ie), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else tick <= ~tick;
  end

  // {nine_bit_en, par_en, par_odd, stop, frame_bits[8:0]}
  localparam logic [12:0] VEC [7] = '{
    13'b0_0_0_1_010100101,
    13'b1_0_0_1_111000011,
    13'b0_1_0_1_000110101,
    13'b0_1_1_1_000110101,
    13'b0_0_0_0_001011010,
    13'b1_0_0_0_000000000,
    13'b1_1_1_1_100000001
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic b, input int n);
    rxd = b;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send(input logic [8:0] bits, input int nb, input logic stop);
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) hold(bits[i], 16);
    hold(stop, 10);
    hold(1'b1, 6);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0; rd_addr = 2'd0;
    nine_bit_en = 1'b0; par_en = 1'b0; par_odd = 1'b0; perr_ie = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1, 4);

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R12 reset", d, 0);
    end

    // table walk: R1 R2 R3 R6 R4 R7 R11
    foreach (VEC[k]) begin
      logic [8:0] bits;
      int nb;
      logic pe, fe, bk;
      bits = VEC[k][8:0];
      @(negedge clk);
      nine_bit_en = VEC[k][12]; par_en = VEC[k][11]; par_odd = VEC[k][10];
      nb = nine_bit_en ? 9 : 8;
      pe = par_en && ((^bits) != par_odd);
      fe = !VEC[k][9];
      bk = (bits == 9'd0) && !VEC[k][9];
      send(bits, nb, VEC[k][9]);
      rd(2'd0, d); chk("R2 R3 status1", d, {2'b00, 1'b1, 3'b000, fe, pe});
      rd(2'd1, d); chk("R6 R9 status2", d, {6'd0, bk, 1'b1});
      rd(2'd3, d); chk("R1 R6 ninth bit", d, {bits[8], 7'd0});
      rd(2'd2, d); chk("R1 data", d, bits[7:0]);
      rd(2'd0, d); chk("R4 status1 cleared", d, 0);
      rd(2'd1, d); chk("R7 break cleared", d, 8'h01);
      hold(1'b1, 100);
      rd(2'd1, d); chk("R11 busy before idle", d, 8'h01);
      hold(1'b1, 100);
      rd(2'd1, d); chk("R11 busy after idle", d, 8'h00);
    end

    // R4 data read alone clears nothing; late flag survives
    @(negedge clk); nine_bit_en = 1'b0; par_en = 1'b0;
    send(9'h011, 8, 1'b1);
    rd(2'd2, d);
    rd(2'd0, d); chk("R4 data-only read keeps flag", d, 8'h20);
    rd(2'd2, d);
    rd(2'd0, d); chk("R4 cleared", d, 8'h00);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(1'b1, 16);
    hold(1'b1, 2);
    rd(2'd0, d); chk("R4 status read before char", d, 8'h00);
    hold(1'b1, 14);
    rd(2'd2, d); chk("R4 data", d, 8'hFF);
    rd(2'd0, d); chk("R4 late flag stays set", d, 8'h20);
    rd(2'd2, d);
    hold(1'b1, 200);

    // R5 interrupt gating
    @(negedge clk); par_en = 1'b1; par_odd = 1'b1; perr_ie = 1'b1;
    send(9'h035, 8, 1'b1);
    @(negedge clk); #1 chk("R5 irq enabled", err_irq, 1);
    perr_ie = 1'b0;
    #1 chk("R5 irq masked", err_irq, 0);
    perr_ie = 1'b1;
    rd(2'd0, d); rd(2'd2, d);
    #1 chk("R5 irq after clear", err_irq, 0);
    par_en = 1'b0; perr_ie = 1'b0;
    hold(1'b1, 200);

    // R9 R10 false start
    hold(1'b0, 1);
    rd(2'd1, d); chk("R9 busy at first low tick", d, 8'h01);
    hold(1'b0, 1);
    hold(1'b1, 20);
    rd(2'd1, d); chk("R10 busy cleared on false start", d, 8'h00);
    rd(2'd0, d); chk("R10 nothing loaded", d, 8'h00);
    hold(1'b1, 200);

    // R8 break re-arm
    hold(1'b0, 16 * 9 + 10);
    rd(2'd1, d); chk("R6 first break", d, 8'h03);
    rd(2'd2, d);
    hold(1'b0, 160);
    rd(2'd1, d); chk("R8 no re-set while line low", d, 8'h01);
    rd(2'd0, d); chk("R8 second break framing", d, 8'h22);
    hold(1'b1, 250);
    rd(2'd0, d); rd(2'd1, d); rd(2'd2, d);
    hold(1'b1, 200);
    send(9'h000, 8, 1'b0);
    rd(2'd1, d); chk("R8 break after line high", d[1], 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule